// File: doc/BRIEF.md
# SCSI Initiator Arbitration and Selection Sequencer

This block is a hardware sequencer for the initiator side of a parallel SCSI bus. After a start pulse it waits for the bus to go free and then arbitrates with the fixed host ID, retrying up to a limit. When it wins, it raises the attention and select lines and addresses one target. When the target answers, it sends a single identify message byte through a REQ/ACK handshake. At the end it pulses `done` and reports a result code. All bus delays and timeouts are counted in clock cycles and set by parameters.

Bus outputs are assert-level: a 1 on `bsyOut`, `selOut`, `atnOut`, `ackOut` or a bit of `dataOut` means the initiator pulls that line. The inputs are the bus as observed, which is the wired-OR of every driver including this block. The command, data and status phases are handled elsewhere.

Top module: `scsi_arbsel_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, the block drives no bus line: `bsyOut`, `selOut`, `atnOut` and `ackOut` are 0 and `dataOut` is 0.
- R2: After `start`, the block asserts nothing while `busBsyIn` is high. If BSY stays high for `BUSFREE_CYC` cycles, the run ends with result 1 (bus busy timeout).
- R3: An arbitration attempt asserts `bsyOut` with `dataOut` carrying only bit `HOST_ID`. It evaluates the outcome exactly `ARB_CYC` cycles after `bsyOut` rises.
- R4: An attempt is won only when `busDataIn` has no asserted bit above `HOST_ID` and `lostArbIn` is low. Otherwise the block releases BSY and the data lines and retries from the bus-free wait.
- R5: After `MAX_TRIES` lost attempts the run ends with result 2 (arbitration lost), and every bus line is released.
- R6: After a win, `atnOut` rises exactly one cycle before `selOut`.
- R7: `CLR_CYC` cycles after `selOut` rises, `dataOut` becomes the OR of bit `targetId` and bit `HOST_ID`. One cycle later `bsyOut` is released while `selOut` stays high.
- R8: When the target asserts BSY, `selOut` and `dataOut` are released. If no BSY arrives within `SEL_CYC` cycles, the run ends with result 3 (selection timeout), and SEL, ATN and the data lines are released.
- R9: On REQ in message-out phase (`busPhaseIn` = {MSG,C/D,I/O} = 3'b110), the block drives the identify byte and asserts `ackOut` until REQ falls. The byte is 0x80 | `lun` in bits 2:0, with bit 6 also set when `discEnable` was high at start. The run ends with result 0.
- R10: A REQ in any other phase, or no REQ within `SEL_CYC` cycles, drops the message without asserting ACK and still ends with result 0 (success).
- R11: `done` is a single-cycle pulse that comes with the `result` of the run. `busy` is high from the accepted start through `done`, and `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| targetId | input | 3 | ID of the target to select, captured at start |
| lun | input | 3 | Logical unit for the identify byte, captured at start |
| discEnable | input | 1 | Grants disconnect privilege in the identify byte, captured at start |
| busBsyIn | input | 1 | Observed BSY line |
| busDataIn | input | 8 | Observed data lines |
| lostArbIn | input | 1 | Lost-arbitration indication from the bus interface |
| busReqIn | input | 1 | Observed REQ line from the target |
| busPhaseIn | input | 3 | Observed {MSG, C/D, I/O} phase lines |
| bsyOut | output | 1 | Assert BSY |
| selOut | output | 1 | Assert SEL |
| atnOut | output | 1 | Assert ATN |
| ackOut | output | 1 | Assert ACK |
| dataOut | output | 8 | Data line bits to assert |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 success, 1 bus busy, 2 arbitration lost, 3 selection timeout |

## Verification
The bench measures the arbitration delay, the ATN-to-SEL spacing and the bus-clear delay to the exact cycle. An off-by-one timer would show up as a stamp that is one cycle out, and a swapped ATN/SEL order would show up as a zero or negative gap. Arbitration is tested against a higher and a lower competing ID and against the lost-arbitration input. A reversed priority compare would then win against ID 7 or lose against ID 3. A retry counter with the wrong bound would change the number of BSY pulses in a lost run. A sequencer that treated a wrong phase or a missing REQ as fatal would report a failure code, and one that drove BSY while the bus was busy would be caught in the bus-free wait test.

// File: rtl/arbsel_pkg.sv
package arbsel_pkg;

  typedef enum logic [1:0] {
    RES_OK          = 2'd0,
    RES_BUS_BUSY    = 2'd1,
    RES_ARB_LOST    = 2'd2,
    RES_SEL_TIMEOUT = 2'd3
  } result_e;

  typedef enum logic [1:0] {
    TM_FREE,
    TM_ARB,
    TM_CLEAR,
    TM_SEL
  } tmr_sel_e;

  // {MSG, C/D, I/O} for message-out
  localparam logic [2:0] PHASE_MSG_OUT = 3'b110;

  typedef struct packed {
    logic     capture;
    logic     tmrClr;
    tmr_sel_e tmrSel;
    logic     setArb;
    logic     clrBsy;
    logic     setAtn;
    logic     clrAtn;
    logic     setSel;
    logic     clrSel;
    logic     loadSel;
    logic     loadIdent;
    logic     clrData;
    logic     setAck;
    logic     clrAck;
    logic     attClr;
    logic     attInc;
    logic     resLoad;
    result_e  resCode;
  } strobe_t;

endpackage

// File: rtl/arbsel_dpath.sv
module arbsel_dpath
  import arbsel_pkg::*;
#(
  parameter int HOST_ID     = 7,
  parameter int ARB_CYC     = 120,
  parameter int CLR_CYC     = 60,
  parameter int BUSFREE_CYC = 12_500_000,
  parameter int SEL_CYC     = 12_500_000,
  parameter int MAX_TRIES   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [2:0] targetId,
  input  logic [2:0] lun,
  input  logic       discEnable,
  input  logic [7:0] busDataIn,
  input  logic       lostArbIn,
  output logic       bsyOut,
  output logic       selOut,
  output logic       atnOut,
  output logic       ackOut,
  output logic [7:0] dataOut,
  output logic [1:0] result,
  output logic       tmrDone,
  output logic       attLast,
  output logic       arbWon
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXC = maxOf(maxOf(ARB_CYC, CLR_CYC), maxOf(BUSFREE_CYC, SEL_CYC));
  localparam int TW   = $clog2(MAXC) + 1;
  localparam int AW   = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  localparam logic [TW-1:0] ARB_LIM  = TW'(ARB_CYC - 1);
  localparam logic [TW-1:0] CLR_LIM  = TW'(CLR_CYC - 1);
  localparam logic [TW-1:0] FREE_LIM = TW'(BUSFREE_CYC - 1);
  localparam logic [TW-1:0] SEL_LIM  = TW'(SEL_CYC - 1);
  localparam logic [AW-1:0] ATT_LIM  = AW'(MAX_TRIES - 1);

  localparam logic [7:0] HOST_BIT   = 8'd1 << HOST_ID;
  localparam logic [7:0] ABOVE_MASK = ~(HOST_BIT | (HOST_BIT - 8'd1));

  logic [TW-1:0] tmrCnt;
  logic [TW-1:0] tmrLim;
  logic [AW-1:0] attCnt;
  logic [2:0]    tgtQ;
  logic [7:0]    identQ;
  logic [7:0]    dataQ;
  logic          bsyQ, selQ, atnQ, ackQ;
  result_e       resQ;

  always_comb begin
    unique case (stb.tmrSel)
      TM_FREE:  tmrLim = FREE_LIM;
      TM_ARB:   tmrLim = ARB_LIM;
      TM_CLEAR: tmrLim = CLR_LIM;
      default:  tmrLim = SEL_LIM;
    endcase
  end

  assign tmrDone = (tmrCnt == tmrLim);
  assign attLast = (attCnt == ATT_LIM);
  assign arbWon  = ((busDataIn & ABOVE_MASK) == 8'd0) && !lostArbIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
      attCnt <= '0;
      tgtQ   <= '0;
      identQ <= '0;
      dataQ  <= '0;
      bsyQ   <= 1'b0;
      selQ   <= 1'b0;
      atnQ   <= 1'b0;
      ackQ   <= 1'b0;
      resQ   <= RES_OK;
    end else begin
      if (stb.tmrClr)       tmrCnt <= '0;
      else if (!tmrDone)    tmrCnt <= tmrCnt + 1'b1;

      if (stb.attClr)       attCnt <= '0;
      else if (stb.attInc)  attCnt <= attCnt + 1'b1;

      if (stb.capture) begin
        tgtQ   <= targetId;
        identQ <= {1'b1, discEnable, 3'b000, lun};
      end

      if (stb.setArb) begin
        bsyQ  <= 1'b1;
        dataQ <= HOST_BIT;
      end
      if (stb.clrBsy)    bsyQ  <= 1'b0;
      if (stb.setAtn)    atnQ  <= 1'b1;
      if (stb.clrAtn)    atnQ  <= 1'b0;
      if (stb.setSel)    selQ  <= 1'b1;
      if (stb.clrSel)    selQ  <= 1'b0;
      if (stb.setAck)    ackQ  <= 1'b1;
      if (stb.clrAck)    ackQ  <= 1'b0;
      if (stb.loadSel)   dataQ <= HOST_BIT | (8'd1 << tgtQ);
      if (stb.loadIdent) dataQ <= identQ;
      if (stb.clrData)   dataQ <= 8'd0;
      if (stb.resLoad)   resQ  <= stb.resCode;
    end
  end

  assign bsyOut  = bsyQ;
  assign selOut  = selQ;
  assign atnOut  = atnQ;
  assign ackOut  = ackQ;
  assign dataOut = dataQ;
  assign result  = resQ;

endmodule

// File: rtl/arbsel_ctrl.sv
module arbsel_ctrl
  import arbsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       busBsyIn,
  input  logic       busReqIn,
  input  logic [2:0] busPhaseIn,
  input  logic       tmrDone,
  input  logic       attLast,
  input  logic       arbWon,
  output strobe_t    stb,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_FREE, S_ARB, S_SEL_ON, S_SETTLE, S_SEL_DRV,
    S_SEL_WAIT, S_MSG_WAIT, S_MSG_DATA, S_MSG_ACK, S_FINISH
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    stb.tmrSel  = TM_FREE;
    stb.resCode = RES_OK;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stb.capture = 1'b1;
          stb.tmrClr  = 1'b1;
          stb.attClr  = 1'b1;
          nextState   = S_FREE;
        end
      end
      S_FREE: begin
        stb.tmrSel = TM_FREE;
        if (!busBsyIn) begin
          stb.setArb = 1'b1;
          stb.tmrClr = 1'b1;
          nextState  = S_ARB;
        end else if (tmrDone) begin
          stb.resLoad = 1'b1;
          stb.resCode = RES_BUS_BUSY;
          nextState   = S_FINISH;
        end
      end
      S_ARB: begin
        stb.tmrSel = TM_ARB;
        if (tmrDone) begin
          if (arbWon) begin
            stb.setAtn = 1'b1;
            nextState  = S_SEL_ON;
          end else begin
            stb.clrBsy  = 1'b1;
            stb.clrData = 1'b1;
            stb.tmrClr  = 1'b1;
            if (attLast) begin
              stb.resLoad = 1'b1;
              stb.resCode = RES_ARB_LOST;
              nextState   = S_FINISH;
            end else begin
              stb.attInc = 1'b1;
              nextState  = S_FREE;
            end
          end
        end
      end
      S_SEL_ON: begin
        stb.setSel = 1'b1;
        stb.tmrClr = 1'b1;
        nextState  = S_SETTLE;
      end
      S_SETTLE: begin
        stb.tmrSel = TM_CLEAR;
        if (tmrDone) begin
          stb.loadSel = 1'b1;
          nextState   = S_SEL_DRV;
        end
      end
      S_SEL_DRV: begin
        stb.clrBsy = 1'b1;
        stb.tmrClr = 1'b1;
        nextState  = S_SEL_WAIT;
      end
      S_SEL_WAIT: begin
        stb.tmrSel = TM_SEL;
        if (busBsyIn) begin
          stb.clrSel  = 1'b1;
          stb.clrData = 1'b1;
          stb.tmrClr  = 1'b1;
          nextState   = S_MSG_WAIT;
        end else if (tmrDone) begin
          stb.clrSel  = 1'b1;
          stb.clrData = 1'b1;
          stb.clrAtn  = 1'b1;
          stb.resLoad = 1'b1;
          stb.resCode = RES_SEL_TIMEOUT;
          nextState   = S_FINISH;
        end
      end
      S_MSG_WAIT: begin
        stb.tmrSel = TM_SEL;
        if (busReqIn && busPhaseIn == PHASE_MSG_OUT) begin
          stb.loadIdent = 1'b1;
          nextState     = S_MSG_DATA;
        end else if (busReqIn || tmrDone) begin
          stb.clrAtn  = 1'b1;
          stb.resLoad = 1'b1;
          stb.resCode = RES_OK;
          nextState   = S_FINISH;
        end
      end
      S_MSG_DATA: begin
        stb.setAck = 1'b1;
        stb.clrAtn = 1'b1;
        nextState  = S_MSG_ACK;
      end
      S_MSG_ACK: begin
        if (!busReqIn) begin
          stb.clrAck  = 1'b1;
          stb.clrData = 1'b1;
          stb.resLoad = 1'b1;
          stb.resCode = RES_OK;
          nextState   = S_FINISH;
        end
      end
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);

endmodule

// File: rtl/scsi_arbsel_seq.sv
module scsi_arbsel_seq
  import arbsel_pkg::*;
#(
  parameter int HOST_ID     = 7,
  parameter int ARB_CYC     = 120,
  parameter int CLR_CYC     = 60,
  parameter int BUSFREE_CYC = 12_500_000,
  parameter int SEL_CYC     = 12_500_000,
  parameter int MAX_TRIES   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] targetId,
  input  logic [2:0] lun,
  input  logic       discEnable,
  input  logic       busBsyIn,
  input  logic [7:0] busDataIn,
  input  logic       lostArbIn,
  input  logic       busReqIn,
  input  logic [2:0] busPhaseIn,
  output logic       bsyOut,
  output logic       selOut,
  output logic       atnOut,
  output logic       ackOut,
  output logic [7:0] dataOut,
  output logic       busy,
  output logic       done,
  output logic [1:0] result
);

  strobe_t stb;
  logic    tmrDone, attLast, arbWon;

  arbsel_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .busBsyIn(busBsyIn), .busReqIn(busReqIn), .busPhaseIn(busPhaseIn),
    .tmrDone(tmrDone), .attLast(attLast), .arbWon(arbWon),
    .stb(stb), .busy(busy), .done(done)
  );

  arbsel_dpath #(
    .HOST_ID(HOST_ID), .ARB_CYC(ARB_CYC), .CLR_CYC(CLR_CYC),
    .BUSFREE_CYC(BUSFREE_CYC), .SEL_CYC(SEL_CYC), .MAX_TRIES(MAX_TRIES)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .targetId(targetId), .lun(lun), .discEnable(discEnable),
    .busDataIn(busDataIn), .lostArbIn(lostArbIn),
    .bsyOut(bsyOut), .selOut(selOut), .atnOut(atnOut), .ackOut(ackOut),
    .dataOut(dataOut), .result(result),
    .tmrDone(tmrDone), .attLast(attLast), .arbWon(arbWon)
  );

endmodule

// File: rtl/arbsel_chk.sv
module arbsel_chk #(
  parameter int HOST_ID = 7
) (
  input logic       clk,
  input logic       rstN,
  input logic       bsyOut,
  input logic       selOut,
  input logic       atnOut,
  input logic       ackOut,
  input logic [7:0] dataOut,
  input logic       busy,
  input logic       done
);

  localparam logic [7:0] HOST_BIT = 8'd1 << HOST_ID;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!bsyOut && !selOut && !atnOut && !ackOut && dataOut == 8'd0));

  a_r3_arb_host_only: assert property (@(posedge clk) disable iff (!rstN)
    (bsyOut && !selOut) |-> (dataOut == HOST_BIT));

  a_r6_atn_before_sel: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selOut) |-> $past(atnOut));

  a_r8_done_released: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!bsyOut && !selOut && !atnOut && !ackOut && dataOut == 8'd0));

  a_r9_ack_ident: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> (dataOut[7] && dataOut[5:3] == 3'b000));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind scsi_arbsel_seq arbsel_chk #(.HOST_ID(HOST_ID)) uChk (
  .clk(clk), .rstN(rstN), .bsyOut(bsyOut), .selOut(selOut), .atnOut(atnOut),
  .ackOut(ackOut), .dataOut(dataOut), .busy(busy), .done(done)
);

// File: tb/sim_scsi_arbsel_seq.sv
module sim_scsi_arbsel_seq;
  localparam int CLK_PERIOD  = 10;
  localparam int HOST_ID     = 6;
  localparam int ARB_CYC     = 6;
  localparam int CLR_CYC     = 3;
  localparam int BUSFREE_CYC = 40;
  localparam int SEL_CYC     = 50;
  localparam int MAX_TRIES   = 3;
  localparam logic [7:0] HOST_BIT = 8'd1 << HOST_ID;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] targetId = '0;
  logic [2:0] lun = '0;
  logic discEnable = 1'b0;
  logic busBsyIn;
  logic [7:0] busDataIn;
  logic lostArbIn = 1'b0;
  logic busReqIn = 1'b0;
  logic [2:0] busPhaseIn = '0;
  logic bsyOut, selOut, atnOut, ackOut, busy, done;
  logic [7:0] dataOut;
  logic [1:0] result;

  logic extBsy = 1'b0;
  logic tgtBsy = 1'b0;
  logic [7:0] extData = '0;

  assign busBsyIn  = bsyOut | extBsy | tgtBsy;
  assign busDataIn = dataOut | extData;

  scsi_arbsel_seq #(
    .HOST_ID(HOST_ID), .ARB_CYC(ARB_CYC), .CLR_CYC(CLR_CYC),
    .BUSFREE_CYC(BUSFREE_CYC), .SEL_CYC(SEL_CYC), .MAX_TRIES(MAX_TRIES)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .targetId(targetId), .lun(lun),
    .discEnable(discEnable), .busBsyIn(busBsyIn), .busDataIn(busDataIn),
    .lostArbIn(lostArbIn), .busReqIn(busReqIn), .busPhaseIn(busPhaseIn),
    .bsyOut(bsyOut), .selOut(selOut), .atnOut(atnOut), .ackOut(ackOut),
    .dataOut(dataOut), .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // monitor: stamps taken at the falling edge
  int cyc = 0;
  int bsyRise = 0, atnRise = 0, selRise = 0, selDataT = 0, bsyFallSel = 0;
  int arbCount = 0, ackCount = 0, doneCount = 0, arbBad = 0, earlyArb = 0;
  logic pBsy = 0, pAtn = 0, pSel = 0, pAck = 0, pExtBsy = 0;
  logic [7:0] pData = '0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bsyOut && !pBsy) begin
      bsyRise = cyc;
      arbCount = arbCount + 1;
      if (pExtBsy) earlyArb = earlyArb + 1;
    end
    if (atnOut && !pAtn) atnRise = cyc;
    if (selOut && !pSel) selRise = cyc;
    if (selOut && bsyOut && pData == HOST_BIT && dataOut != HOST_BIT) selDataT = cyc;
    if (!bsyOut && pBsy && selOut) bsyFallSel = cyc;
    if (bsyOut && !selOut && dataOut != HOST_BIT) arbBad = arbBad + 1;
    if (ackOut && !pAck) ackCount = ackCount + 1;
    if (done) doneCount = doneCount + 1;
    pBsy = bsyOut; pAtn = atnOut; pSel = selOut; pAck = ackOut;
    pData = dataOut; pExtBsy = extBsy;
  end

  // target model
  logic tgtEn = 1'b0;
  logic tgtRst = 1'b0;
  int   tgtId = 0;
  int   msgMode = 0;   // 0 message-out, 1 other phase, 2 no REQ
  int   tst = 0;
  logic [7:0] gotByte = '0;
  logic [7:0] selPat = '0;

  always @(negedge clk) begin
    if (tgtRst) begin
      tst = 0; tgtBsy = 1'b0; busReqIn = 1'b0; busPhaseIn = '0;
      gotByte = '0; selPat = '0;
    end else begin
      case (tst)
        0: if (tgtEn && selOut && !bsyOut && dataOut[tgtId]) begin
             selPat = dataOut; tgtBsy = 1'b1; tst = 1;
           end
        1: if (!selOut) begin
             if (msgMode != 2) begin
               busReqIn = 1'b1;
               busPhaseIn = (msgMode == 0) ? 3'b110 : 3'b011;
             end
             tst = 2;
           end
        2: if (ackOut) begin
             gotByte = dataOut; busReqIn = 1'b0; tst = 3;
           end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prep(input int tid, input int mode, input bit en);
    @(posedge clk); #1;
    tgtRst = 1'b1; extBsy = 1'b0; extData = '0; lostArbIn = 1'b0;
    tgtId = tid; msgMode = mode; tgtEn = en;
    repeat (2) @(posedge clk);
    #1 tgtRst = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic pulse_start(input logic [2:0] tid, input logic [2:0] l, input logic dis);
    @(posedge clk); #1;
    targetId = tid; lun = l; discEnable = dis; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(output logic [1:0] res, output int waited);
    waited = 0;
    res = '0;
    while (waited < 2000) begin
      @(negedge clk);
      waited++;
      if (done) begin
        res = result;
        break;
      end
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !bsyOut && !selOut && !atnOut && !ackOut && dataOut == 0,
        "R1 reset quiet", {busy, bsyOut, selOut, atnOut, ackOut}, 0);
    chk(dataOut == 0, "R1 reset data", dataOut, 0);
  endtask

  task automatic t_select_ok(input int tid, input int l, input bit dis, input logic [7:0] expId);
    logic [1:0] res; int w; int arb0, ack0, bad0;
    prep(tid, 0, 1'b1);
    arb0 = arbCount; ack0 = ackCount; bad0 = arbBad;
    pulse_start(3'(tid), 3'(l), dis);
    wait_done(res, w);
    chk(res == 0, "R9 success result", res, 0);
    chk(gotByte == expId, "R9 identify byte", gotByte, expId);
    chk(ackCount - ack0 == 1, "R9 one ack", ackCount - ack0, 1);
    chk(atnRise - bsyRise == ARB_CYC, "R3 arbitration delay", atnRise - bsyRise, ARB_CYC);
    chk(arbBad == bad0, "R3 host bit only", arbBad - bad0, 0);
    chk(selRise - atnRise == 1, "R6 atn before sel", selRise - atnRise, 1);
    chk(selDataT - selRise == CLR_CYC, "R7 clear settle delay", selDataT - selRise, CLR_CYC);
    chk(bsyFallSel - selDataT == 1, "R7 bsy release", bsyFallSel - selDataT, 1);
    chk(selPat == (HOST_BIT | (8'd1 << tid)), "R7 select pattern", selPat, HOST_BIT | (8'd1 << tid));
    chk(arbCount - arb0 == 1, "R4 single attempt", arbCount - arb0, 1);
    chk(!bsyOut && !selOut && !atnOut && !ackOut && dataOut == 0, "R8 released at done",
        {bsyOut, selOut, atnOut, ackOut}, 0);
    @(negedge clk);
    chk(!done && !busy, "R11 done pulse single", {done, busy}, 0);
  endtask

  task automatic t_busfree_timeout();
    logic [1:0] res; int w; int arb0;
    prep(1, 0, 1'b1);
    @(posedge clk); #1 extBsy = 1'b1;
    arb0 = arbCount;
    pulse_start(3'd1, 3'd0, 1'b0);
    wait_done(res, w);
    chk(res == 1, "R2 bus busy result", res, 1);
    chk(w >= BUSFREE_CYC - 1 && w <= BUSFREE_CYC + 2, "R2 bus busy timeout length", w, BUSFREE_CYC);
    chk(arbCount == arb0, "R2 no arbitration while busy", arbCount - arb0, 0);
  endtask

  task automatic t_busfree_wait();
    logic [1:0] res; int w;
    prep(2, 0, 1'b1);
    @(posedge clk); #1 extBsy = 1'b1;
    pulse_start(3'd2, 3'd1, 1'b0);
    repeat (15) @(posedge clk);
    #1;
    chk(busy && !bsyOut && dataOut == 0, "R2 waits while bus busy", {busy, bsyOut}, 2);
    extBsy = 1'b0;
    wait_done(res, w);
    chk(res == 0, "R2 proceeds after bus free", res, 0);
    chk(earlyArb == 0, "R2 no bsy while bus busy", earlyArb, 0);
  endtask

  task automatic t_lose_priority();
    logic [1:0] res; int w; int arb0;
    prep(2, 0, 1'b1);
    @(posedge clk); #1 extData = 8'h80;
    arb0 = arbCount;
    pulse_start(3'd2, 3'd0, 1'b0);
    wait_done(res, w);
    chk(res == 2, "R5 arbitration lost result", res, 2);
    chk(arbCount - arb0 == MAX_TRIES, "R5 attempt count", arbCount - arb0, MAX_TRIES);
    chk(!bsyOut && dataOut == 0, "R5 released after loss", {bsyOut, dataOut}, 0);
  endtask

  task automatic t_win_low();
    logic [1:0] res; int w; int arb0;
    prep(1, 0, 1'b1);
    @(posedge clk); #1 extData = 8'h08;
    arb0 = arbCount;
    pulse_start(3'd1, 3'd2, 1'b1);
    wait_done(res, w);
    chk(res == 0, "R4 wins over lower id", res, 0);
    chk(arbCount - arb0 == 1, "R4 lower id single attempt", arbCount - arb0, 1);
  endtask

  task automatic t_lostarb_input();
    logic [1:0] res; int w; int arb0;
    prep(1, 0, 1'b1);
    @(posedge clk); #1 lostArbIn = 1'b1;
    arb0 = arbCount;
    pulse_start(3'd1, 3'd0, 1'b0);
    wait_done(res, w);
    chk(res == 2, "R4 lost arbitration input", res, 2);
    chk(arbCount - arb0 == MAX_TRIES, "R4 retries on lost input", arbCount - arb0, MAX_TRIES);
  endtask

  task automatic t_lose_once();
    logic [1:0] res; int w; int arb0;
    prep(3, 0, 1'b1);
    @(posedge clk); #1 lostArbIn = 1'b1;
    arb0 = arbCount;
    pulse_start(3'd3, 3'd4, 1'b0);
    while (!(arbCount == arb0 + 1 && !bsyOut)) @(negedge clk);
    @(posedge clk); #1 lostArbIn = 1'b0;
    wait_done(res, w);
    chk(res == 0, "R4 retry then win", res, 0);
    chk(arbCount - arb0 == 2, "R4 two attempts", arbCount - arb0, 2);
    chk(gotByte == 8'h84, "R9 identify after retry", gotByte, 8'h84);
  endtask

  task automatic t_sel_timeout();
    logic [1:0] res; int w;
    prep(4, 0, 1'b0);
    pulse_start(3'd4, 3'd0, 1'b0);
    wait_done(res, w);
    chk(res == 3, "R8 selection timeout", res, 3);
    chk(!selOut && !atnOut && dataOut == 0, "R8 released after timeout", {selOut, atnOut}, 0);
  endtask

  task automatic t_phase_mismatch(input int mode);
    logic [1:0] res; int w; int ack0;
    prep(5, mode, 1'b1);
    ack0 = ackCount;
    pulse_start(3'd5, 3'd1, 1'b1);
    wait_done(res, w);
    chk(res == 0, "R10 message dropped still success", res, 0);
    chk(ackCount == ack0, "R10 no ack", ackCount - ack0, 0);
  endtask

  task automatic t_start_ignored();
    logic [1:0] res; int w; int d0;
    prep(2, 0, 1'b1);
    d0 = doneCount;
    pulse_start(3'd2, 3'd3, 1'b0);
    repeat (3) @(posedge clk);
    chk(busy, "R11 busy after start", busy, 1);
    pulse_start(3'd4, 3'd7, 1'b1);
    wait_done(res, w);
    chk(res == 0 && gotByte == 8'h83, "R11 second start ignored", gotByte, 8'h83);
    repeat (20) @(negedge clk);
    chk(!busy && doneCount - d0 == 1, "R11 single run", doneCount - d0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_select_ok(2, 5, 1'b1, 8'hC5);
    t_select_ok(0, 3, 1'b0, 8'h83);
    t_busfree_timeout();
    t_busfree_wait();
    t_lose_priority();
    t_win_low();
    t_lostarb_input();
    t_lose_once();
    t_sel_timeout();
    t_phase_mismatch(1);
    t_phase_mismatch(2);
    t_start_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule